// File: doc/BRIEF.md
# Programmable PWM Channel Timer

This block is one pulse-width channel. It runs on the system clock, but its counter moves only on a one-cycle strobe that stands in for a prescaled clock. Software programs it through a write strobe with a two-bit address. It holds a period, a duty value and a control word with three flags: enable, starting polarity, and center alignment. The counter compares against the period and duty values to form the waveform.

In left-aligned mode the counter counts up and wraps. In center-aligned mode it climbs to the period and falls back to zero, so the frame is twice as long. The compare logic is the same in both modes. When the channel is not running, the pin simply repeats a general-purpose port bit.

New period and duty values wait in a shadow stage. They are taken only when the counter restarts, or while the channel is stopped. A frame in progress therefore always keeps the values it began with.

Top module: `pwm_chan_timer`

## Requirements
- R1: After reset the channel is stopped, and `pwm_out` follows `port_bit` in both directions.
- R2: While the channel is not running, `pwm_out` equals `port_bit`. Strobes on `clk_src_tick` do not change this.
- R3: Setting the enable flag does not start the waveform at once. `pwm_out` keeps showing `port_bit` until the next `clk_src_tick`. The running waveform starts with the counter at 0.
- R4: In left-aligned mode the counter advances only on `clk_src_tick`. It runs 0, 1, … up to period−1 and then wraps to 0, so one frame lasts `period` strobes.
- R5: The active level is high when the polarity flag is 1 and low when it is 0. The output is at its active level while count < duty and at the opposite level for the rest of the frame.
- R6: If duty ≥ period, or if period is 0, the output stays at its active level for as long as the channel runs.
- R7: In center-aligned mode the count runs 0 up to period and back down to 1, then starts over. One frame is 2·period strobes. The active/inactive rule of R5 uses this count.
- R8: A period or duty value written while the channel runs takes effect only at the next counter restart, when the count returns to 0.
- R9: Clearing the enable flag stops the channel. `pwm_out` returns to `port_bit` within two clock cycles after the write strobe, with no strobe on `clk_src_tick` needed.
- R10: Register map, with writes taking effect when `wr_en` is high:
  - Address 0 is the control word: bit0 enable, bit1 polarity, bit2 center alignment.
  - Address 1 is the period.
  - Address 2 is the duty.
  - A write to address 3 has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_src_tick | input | 1 | One-cycle enable standing for the prescaled clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| port_bit | input | 1 | General-purpose port data shown on the pin while stopped |
| pwm_out | output | 1 | Pin drive |

## Verification
The assertions assume that `clk_src_tick` is a single-cycle pulse with idle system clocks between pulses. They also assume that the mode and polarity flags change only while the channel is stopped, because switching them mid-frame makes the count bound and the output-level checks meaningless. The bench holds to both assumptions. Every strobe is one clock wide and is followed by at least one idle clock. Every scenario first clears enable and only then rewrites the mode, polarity, period and duty before enabling again. Only period and duty are rewritten while the channel runs, to exercise the shadow stage.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

   localparam int unsigned REG_ADDR_W = 2;

   localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADDR_PER  = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADDR_DUTY = 2'd2;

   localparam int unsigned CTRL_W = 3;

   // control word, MSB first: center, polarity, enable
   typedef struct packed {
      logic center;
      logic pol;
      logic enable;
   } ctrl_t;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned ADDR_W = REG_ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              load,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  per_act,
   output logic [CNT_W-1:0]  duty_act
);

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("pwm_chan_regs: CNT_W must hold the control word");
      end
      if (ADDR_W != REG_ADDR_W) begin : g_bad_addr
         $error("pwm_chan_regs: ADDR_W must match the register map");
      end
   endgenerate

   logic [CNT_W-1:0] per_sh;
   logic [CNT_W-1:0] duty_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         per_sh  <= '0;
         duty_sh <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
            ADDR_PER:  per_sh  <= wr_data;
            ADDR_DUTY: duty_sh <= wr_data;
            default:   ;
         endcase
      end
   end

   // active copies move only at a frame boundary or while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_act  <= '0;
         duty_act <= '0;
      end else if (load) begin
         per_act  <= per_sh;
         duty_act <= duty_sh;
      end
   end

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en_req,
   input  logic             center,
   input  logic [CNT_W-1:0] per_act,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output cnt_dir_e         dir,
   output logic             restart
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             center_mode;
   logic [CNT_W-1:0] nxt_cnt;
   cnt_dir_e         nxt_dir;
   logic             left_wrap;

   generate
      if (CENTER_EN) begin : g_center
         assign center_mode = center;
      end else begin : g_left_only
         logic unused_center;
         assign unused_center = center;
         assign center_mode   = 1'b0;
      end
   endgenerate

   // wrap when the next count would reach the period (extra bit avoids overflow)
   assign left_wrap = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, per_act};

   always_comb begin
      nxt_cnt = cnt;
      nxt_dir = dir;
      restart = 1'b0;
      if (!run) begin
         nxt_cnt = '0;
         nxt_dir = DIR_UP;
      end else if (tick) begin
         if (per_act == '0) begin
            nxt_cnt = '0;
            nxt_dir = DIR_UP;
            restart = 1'b1;
         end else if (center_mode) begin
            if (dir == DIR_UP) begin
               nxt_cnt = cnt + ONE;
               if (cnt == per_act - ONE) nxt_dir = DIR_DOWN;
            end else begin
               nxt_cnt = cnt - ONE;
               if (cnt == ONE) begin
                  nxt_dir = DIR_UP;
                  restart = 1'b1;
               end
            end
         end else if (left_wrap) begin
            nxt_cnt = '0;
            restart = 1'b1;
         end else begin
            nxt_cnt = cnt + ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         dir <= DIR_UP;
      end else begin
         cnt <= nxt_cnt;
         dir <= nxt_dir;
      end
   end

   // enable is armed at once but the channel runs from the next source tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run <= 1'b0;
      else if (!en_req) run <= 1'b0;
      else if (tick)    run <= 1'b1;
   end

endmodule

// File: rtl/pwm_chan_outmux.sv
module pwm_chan_outmux #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             run,
   input  logic             pol,
   input  logic             port_bit,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] per_act,
   input  logic [CNT_W-1:0] duty_act,
   output logic             pin
);

   logic active;
   logic wave;

   assign active = (duty_act >= per_act) || (cnt < duty_act);
   assign wave   = pol ? active : ~active;
   assign pin    = run ? wave : port_bit;

endmodule

// File: rtl/pwm_chan_timer.sv
module pwm_chan_timer
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned ADDR_W    = REG_ADDR_W,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_src_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              port_bit,
   output logic              pwm_out
);

   ctrl_t            ctrl;
   logic [CNT_W-1:0] per_act;
   logic [CNT_W-1:0] duty_act;
   logic [CNT_W-1:0] cnt;
   cnt_dir_e         dir;
   logic             run;
   logic             restart;
   logic             load;

   assign load = restart | ~run;

   pwm_chan_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .load     (load),
      .ctrl     (ctrl),
      .per_act  (per_act),
      .duty_act (duty_act)
   );

   pwm_chan_counter #(.CNT_W(CNT_W), .CENTER_EN(CENTER_EN)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (clk_src_tick),
      .en_req  (ctrl.enable),
      .center  (ctrl.center),
      .per_act (per_act),
      .run     (run),
      .cnt     (cnt),
      .dir     (dir),
      .restart (restart)
   );

   pwm_chan_outmux #(.CNT_W(CNT_W)) u_out (
      .run      (run),
      .pol      (ctrl.pol),
      .port_bit (port_bit),
      .cnt      (cnt),
      .per_act  (per_act),
      .duty_act (duty_act),
      .pin      (pwm_out)
   );

endmodule

// File: rtl/pwm_chan_timer_chk.sv
module pwm_chan_timer_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clk_src_tick,
   input logic             wr_en,
   input logic             port_bit,
   input logic             pwm_out,
   input logic             run,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] per_act,
   input logic [CNT_W-1:0] duty_act,
   input logic             pol
);

   assert_port_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (pwm_out == port_bit));

   assert_start_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(clk_src_tick));

   assert_start_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt == '0));

   assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clk_src_tick && !wr_en) |=> $stable(cnt));

   assert_full_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (duty_act >= per_act)) |-> (pwm_out == pol));

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= per_act));

   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && run && (cnt != '0)) |-> ($stable(per_act) && $stable(duty_act)));

endmodule

bind pwm_chan_timer pwm_chan_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clk_src_tick (clk_src_tick),
   .wr_en        (wr_en),
   .port_bit     (port_bit),
   .pwm_out      (pwm_out),
   .run          (run),
   .cnt          (cnt),
   .per_act      (per_act),
   .duty_act     (duty_act),
   .pol          (ctrl.pol)
);

// File: tb/pwm_chan_timer_tb.sv
`timescale 1ns/1ps
module pwm_chan_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       port_bit = 1'b0;
   logic       pwm_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pwm_chan_timer u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .clk_src_tick (tick),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .port_bit     (port_bit),
      .pwm_out      (pwm_out)
   );

   task automatic check(input logic act, input logic exp, input string req, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // expected level from the requirements: count derived from strobe index
   function automatic logic exp_level(input int idx, input int per, input int duty,
                                      input bit pol, input bit ctr);
      int  c;
      bit  act;
      if (per == 0) c = 0;
      else if (!ctr) c = idx % per;
      else begin
         int pos;
         pos = idx % (2 * per);
         c = (pos <= per) ? pos : 2 * per - pos;
      end
      act = (duty >= per) || (c < duty);
      return pol ? act : !act;
   endfunction

   // stop, program, enable; checks the delayed start (R3)
   task automatic start_chan(input int per, input int duty, input bit pol, input bit ctr);
      wr(2'd0, 8'h00);
      idle(1);
      wr(2'd1, 8'(per));
      wr(2'd2, 8'(duty));
      port_bit = !exp_level(0, per, duty, pol, ctr);
      wr(2'd0, {5'b0, ctr, pol, 1'b1});
      idle(3);
      check(pwm_out, port_bit, "R3", "no waveform before source tick");
      pulse();
      check(pwm_out, exp_level(0, per, duty, pol, ctr), "R3", "first level after tick");
   endtask

   task automatic follow(input int per, input int duty, input bit pol, input bit ctr,
                         input int n, input string req);
      for (int idx = 1; idx < n; idx++) begin
         pulse();
         check(pwm_out, exp_level(idx, per, duty, pol, ctr), req, $sformatf("strobe %0d", idx));
         if (idx % 3 == 0) begin
            idle(2);
            check(pwm_out, exp_level(idx, per, duty, pol, ctr), "R4", "held between strobes");
         end
      end
   endtask

   task automatic t_reset_r1();
      port_bit = 1'b1; idle(1);
      check(pwm_out, 1'b1, "R1", "follows port high after reset");
      port_bit = 1'b0; idle(1);
      check(pwm_out, 1'b0, "R1", "follows port low after reset");
   endtask

   task automatic t_stopped_r2();
      wr(2'd1, 8'd4);
      wr(2'd2, 8'd2);
      port_bit = 1'b1;
      pulse(); pulse();
      check(pwm_out, 1'b1, "R2", "ticks while stopped");
      port_bit = 1'b0; idle(1);
      check(pwm_out, 1'b0, "R2", "port low while stopped");
   endtask

   task automatic t_left_r4();
      start_chan(5, 2, 1'b1, 1'b0);
      follow(5, 2, 1'b1, 1'b0, 16, "R4");
   endtask

   task automatic t_pol_r5();
      start_chan(4, 3, 1'b0, 1'b0);
      follow(4, 3, 1'b0, 1'b0, 12, "R5");
   endtask

   task automatic t_full_r6();
      start_chan(5, 7, 1'b1, 1'b0);
      follow(5, 7, 1'b1, 1'b0, 8, "R6");
      start_chan(0, 0, 1'b0, 1'b0);
      follow(0, 0, 1'b0, 1'b0, 6, "R6");
      start_chan(3, 3, 1'b1, 1'b1);
      follow(3, 3, 1'b1, 1'b1, 8, "R6");
   endtask

   task automatic t_center_r7();
      start_chan(3, 2, 1'b1, 1'b1);
      follow(3, 2, 1'b1, 1'b1, 14, "R7");
      start_chan(4, 1, 1'b0, 1'b1);
      follow(4, 1, 1'b0, 1'b1, 18, "R7");
   endtask

   task automatic t_shadow_r8();
      start_chan(4, 1, 1'b1, 1'b0);
      pulse();
      check(pwm_out, exp_level(1, 4, 1, 1'b1, 1'b0), "R8", "before rewrite");
      wr(2'd1, 8'd6);
      wr(2'd2, 8'd3);
      for (int idx = 2; idx < 16; idx++) begin
         pulse();
         if (idx < 4)
            check(pwm_out, exp_level(idx, 4, 1, 1'b1, 1'b0), "R8", "old frame kept");
         else
            check(pwm_out, exp_level(idx - 4, 6, 3, 1'b1, 1'b0), "R8", "new frame after restart");
      end
   endtask

   task automatic t_stop_r9();
      start_chan(6, 3, 1'b1, 1'b0);
      follow(6, 3, 1'b1, 1'b0, 2, "R9");
      port_bit = 1'b0;
      wr(2'd0, 8'h06);
      idle(1);
      check(pwm_out, 1'b0, "R9", "port low after disable");
      port_bit = 1'b1; idle(1);
      check(pwm_out, 1'b1, "R9", "port high after disable");
   endtask

   task automatic t_addr3_r10();
      start_chan(5, 2, 1'b1, 1'b0);
      pulse();
      wr(2'd3, 8'hFF);
      wr(2'd3, 8'h00);
      for (int idx = 2; idx < 12; idx++) begin
         pulse();
         check(pwm_out, exp_level(idx, 5, 2, 1'b1, 1'b0), "R10", "address 3 write ignored");
      end
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset_r1();
      t_stopped_r2();
      t_left_r4();
      t_pol_r5();
      t_full_r6();
      t_center_r7();
      t_shadow_r8();
      t_stop_r9();
      t_addr3_r10();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got hang expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule